// File: doc/BRIEF.md
# Programmable-Flag FIFO with Retransmit

A single-clock, 18-bit-wide first-in first-out buffer with a parameterised power-of-two depth of 64 words by default. It has two read modes. The level on `mode_sel_i` while the asynchronous master reset `rst_ni` is low picks the mode, and the mode then holds until the next master reset. In standard mode a read request loads the oldest word into a registered output. In first-word-fall-through (FWFT) mode the oldest stored word is shown on the output without any read request, and a read request moves on to the next word.

Five status flags are derived from the stored word count: full, empty, programmable almost-full, programmable almost-empty and half-full. In FWFT mode, full is read as "input not ready" and empty as "output not ready", with the same polarity. The two programmable thresholds come from a small offset-register stage inside the block. That stage is loaded with a one-cycle strobe and returns to its default values only on master reset. A synchronous partial reset empties the FIFO but keeps the offsets and the mode. A retransmit strobe rewinds the read side to memory location 0 so that the data written since the last reset can be read again.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_ni` is low, the FIFO is emptied, the standard-mode output register is cleared to 0, both offsets take their defaults (8 and 8), and the mode is taken from `mode_sel_i` (0 = standard, 1 = FWFT). A later change on `mode_sel_i` has no effect.
- R2: In standard mode, a read of a non-empty FIFO places the oldest word on `rd_data_o` after that clock edge. Otherwise `rd_data_o` holds its value.
- R3: In FWFT mode, whenever `empty_o` is low, `rd_data_o` shows the oldest stored word without any read request. A read moves on to the next word.
- R4: A write while `full_o` is high is dropped, and a read while `empty_o` is high is dropped. Neither changes the count or the data order.
- R5: A simultaneous read and write on a full FIFO performs only the read, so the count becomes DEPTH-1. On an empty FIFO it performs only the write, so the count becomes 1. In every other state both are performed and the count is unchanged.
- R6: `full_o` is high exactly when the count equals DEPTH, and `empty_o` is high exactly when the count is 0. The flags follow the count one clock edge after an operation.
- R7: `afull_o` is high when count + m >= DEPTH, where m is the current full offset.
- R8: `aempty_o` is high when count <= n, where n is the current empty offset.
- R9: `half_o` is high when count > DEPTH/2.
- R10: A retransmit strobe sets the read position to location 0, and the count becomes the number of words written since the last reset (valid when that number is at most DEPTH). A read in the same cycle is dropped, and a write in the same cycle is kept. In FWFT mode, location 0 appears on `rd_data_o` on the next cycle. In standard mode the output register is unchanged.
- R11: `prst_i` high at a clock edge empties the FIFO and clears the standard-mode output register. It takes precedence over a read, a write and a retransmit in the same cycle, and it keeps the offsets and the mode.
- R12: `off_ld_i` high at a clock edge loads `full_off_i` and `empty_off_i` as m and n, starting from the next cycle. The loaded values survive partial reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| mode_sel_i | input | 1 | Read-mode select, sampled during master reset |
| prst_i | input | 1 | Synchronous partial reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 18 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 18 | Read data |
| retx_i | input | 1 | Retransmit strobe |
| off_ld_i | input | 1 | Offset load strobe |
| full_off_i | input | 7 | Full offset m to load |
| empty_off_i | input | 7 | Empty offset n to load |
| full_o | output | 1 | Full / input not ready |
| empty_o | output | 1 | Empty / output not ready |
| afull_o | output | 1 | Programmable almost-full |
| aempty_o | output | 1 | Programmable almost-empty |
| half_o | output | 1 | Half-full |

## Verification
The most sensitive overlaps are a read and a write in the same cycle on a full or an empty FIFO, and a retransmit that falls in the same cycle as a write or a read. The bench drives these overlaps on purpose: it holds both requests for several cycles at each boundary, and it issues a retransmit together with a write after part of the data has been read. A queue-based model decides which of the colliding operations take effect. The flags and data are compared against that model on every clock. Partial reset is also applied together with reads and writes, so that its precedence and the survival of the loaded offsets are checked.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic full;
    logic empty;
    logic afull;
    logic aempty;
    logic half;
  } flags_t;
endpackage

// File: rtl/pff_offset_regs.sv
module pff_offset_regs #(
  parameter int CW        = 7,
  parameter int FULL_DEF  = 8,
  parameter int EMPTY_DEF = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [CW-1:0] full_off_i,
  input  logic [CW-1:0] empty_off_i,
  output logic [CW-1:0] full_off_o,
  output logic [CW-1:0] empty_off_o
);
  // only master reset restores defaults; partial reset is not wired here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_off_o  <= CW'(FULL_DEF);
      empty_off_o <= CW'(EMPTY_DEF);
    end else if (ld_i) begin
      full_off_o  <= full_off_i;
      empty_off_o <= empty_off_i;
    end
  end
endmodule

// File: rtl/pff_ptr_ctrl.sv
module pff_ptr_ctrl #(
  parameter int  DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          retx_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] wptr_q, rptr_q;
  logic          is_full, is_empty;

  // extra pointer bit separates full from empty
  assign count_o  = wptr_q - rptr_q;
  assign is_full  = (count_o == CW'(DEPTH));
  assign is_empty = (count_o == '0);

  assign wr_ok_o = wr_req_i && !is_full && !prst_i;
  assign rd_ok_o = rd_req_i && !is_empty && !prst_i && !retx_i;
  assign waddr_o = wptr_q[AW-1:0];
  assign raddr_o = rptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (prst_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_ok_o) wptr_q <= wptr_q + 1'b1;
      if (retx_i)       rptr_q <= '0;
      else if (rd_ok_o) rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pff_flag_gen.sv
module pff_flag_gen
  import pff_pkg::*;
#(
  parameter int  DEPTH = 64,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] full_off_i,
  input  logic [CW-1:0] empty_off_i,
  output flags_t        flags_o
);
  logic [CW:0] fill_plus_m;

  // widened so a large offset cannot wrap
  assign fill_plus_m    = {1'b0, count_i} + {1'b0, full_off_i};
  assign flags_o.full   = (count_i == CW'(DEPTH));
  assign flags_o.empty  = (count_i == '0);
  assign flags_o.afull  = (fill_plus_m >= (CW+1)'(DEPTH));
  assign flags_o.aempty = (count_i <= empty_off_i);
  assign flags_o.half   = (count_i > CW'(DEPTH / 2));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int  DW            = 18,
  parameter int  DEPTH         = 64,
  parameter int  FULL_OFF_DEF  = 8,
  parameter int  EMPTY_OFF_DEF = 8,
  localparam int AW            = $clog2(DEPTH),
  localparam int CW            = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_sel_i,
  input  logic          prst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          retx_i,
  input  logic          off_ld_i,
  input  logic [CW-1:0] full_off_i,
  input  logic [CW-1:0] empty_off_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          afull_o,
  output logic          aempty_o,
  output logic          half_o
);
  rd_mode_e      mode_q;
  logic          fwft;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count, m_off, n_off;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] mem_q [DEPTH];
  flags_t        flags;

  // mode follows the pin only while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= rd_mode_e'(mode_sel_i);
  end
  assign fwft = (mode_q == MODE_FWFT);

  pff_offset_regs #(
    .CW(CW), .FULL_DEF(FULL_OFF_DEF), .EMPTY_DEF(EMPTY_OFF_DEF)
  ) u_offs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(off_ld_i),
    .full_off_i(full_off_i), .empty_off_i(empty_off_i),
    .full_off_o(m_off), .empty_off_o(n_off)
  );

  pff_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .prst_i(prst_i),
    .wr_req_i(wr_en_i), .rd_req_i(rd_en_i), .retx_i(retx_i),
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok),
    .waddr_o(waddr), .raddr_o(raddr), .count_o(count)
  );

  pff_flag_gen #(.DEPTH(DEPTH)) u_flags (
    .count_i(count), .full_off_i(m_off), .empty_off_i(n_off), .flags_o(flags)
  );

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[waddr] <= wr_data_i;
  end

  // standard mode: registered output advanced by reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dout_q <= '0;
    else if (prst_i)          dout_q <= '0;
    else if (rd_ok && !fwft)  dout_q <= mem_q[raddr];
  end

  // fall-through mode: head of queue shown directly
  assign rd_data_o = fwft ? mem_q[raddr] : dout_q;

  assign full_o   = flags.full;
  assign empty_o  = flags.empty;
  assign afull_o  = flags.afull;
  assign aempty_o = flags.aempty;
  assign half_o   = flags.half;
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          prst_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          retx_i,
  input logic [DW-1:0] rd_data_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          afull_o,
  input logic          half_o
);
  assert_full_drops_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && !rd_en_i && !prst_i && !retx_i |=> full_o);

  assert_empty_drops_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_en_i && !wr_en_i && !prst_i && !retx_i |=> empty_o);

  assert_full_rw_reads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && rd_en_i && !prst_i && !retx_i |=> !full_o);

  assert_empty_rw_writes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wr_en_i && rd_en_i && !prst_i |=> !empty_o);

  assert_std_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwft_i && !rd_en_i && !prst_i |=> $stable(rd_data_o));

  assert_prst_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> empty_o && !full_o && !half_o);

  assert_full_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_full_implies_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o && half_o);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fwft_i(fwft), .prst_i(prst_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .retx_i(retx_i),
  .rd_data_o(rd_data_o), .full_o(full_o), .empty_o(empty_o),
  .afull_o(afull_o), .half_o(half_o)
);

// File: tb/tb_prog_flag_fifo.sv
`timescale 1ns/1ps
module tb_prog_flag_fifo;
  localparam int DW = 18, DEPTH = 64, CW = 7, FDEF = 8, EDEF = 8;

  logic clk = 0, rst_ni = 1, mode_sel = 0, prst = 0;
  logic wr_en = 0, rd_en = 0, retx = 0, off_ld = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [CW-1:0] full_off = '0, empty_off = '0;
  logic full, empty, afull, aempty, half;

  always #2 clk = ~clk;

  prog_flag_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_sel_i(mode_sel), .prst_i(prst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .retx_i(retx), .off_ld_i(off_ld), .full_off_i(full_off), .empty_off_i(empty_off),
    .full_o(full), .empty_o(empty), .afull_o(afull), .aempty_o(aempty), .half_o(half)
  );

  int total = 0, bad = 0;
  string cur_tag = "R1";

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (phase %s) act=%0h exp=%0h t=%0t", req, cur_tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [DW-1:0] hist[$];
  int rdi, cnt_m, moff_f, moff_e;
  logic [DW-1:0] dout_m;
  bit fwft_m, rok, wok;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete(); rdi = 0; dout_m = '0; fwft_m = mode_sel;
      moff_f = FDEF; moff_e = EDEF;
    end else begin
      cnt_m = hist.size() - rdi;
      if (off_ld) begin moff_f = full_off; moff_e = empty_off; end
      if (prst) begin
        hist.delete(); rdi = 0; dout_m = '0;
      end else begin
        rok = rd_en && cnt_m > 0 && !retx;
        wok = wr_en && cnt_m < DEPTH;
        if (rok) begin
          if (!fwft_m) dout_m = hist[rdi];
          rdi++;
        end
        if (wok) hist.push_back(wr_data);
        if (retx) rdi = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      int c;
      c = hist.size() - rdi;
      chk(full == (c == DEPTH), "R6 full", full, c == DEPTH);
      chk(empty == (c == 0), "R6 empty", empty, c == 0);
      chk(afull == (c + moff_f >= DEPTH), "R7 afull", afull, c + moff_f >= DEPTH);
      chk(aempty == (c <= moff_e), "R8 aempty", aempty, c <= moff_e);
      chk(half == (c > DEPTH / 2), "R9 half", half, c > DEPTH / 2);
      if (fwft_m) begin
        if (c > 0) chk(rd_data == hist[rdi], "R3 head", rd_data, hist[rdi]);
      end else begin
        chk(rd_data == dout_m, "R2 dout", rd_data, dout_m);
      end
    end
  end

  task automatic drive(bit w, bit r, bit rt = 0, bit p = 0);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; retx = rt; prst = p; off_ld = 0;
    wr_data = DW'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0);
  endtask

  task automatic load_off(int m, int n);
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; retx = 0; prst = 0;
    off_ld = 1; full_off = CW'(m); empty_off = CW'(n);
  endtask

  task automatic mreset(bit mode);
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; retx = 0; prst = 0; off_ld = 0;
    mode_sel = mode;
    rst_ni = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    mode_sel = ~mode; // must be ignored
    @(negedge clk);
    cur_tag = "R1";
    chk(empty === 1'b1, "R1 empty after reset", empty, 1);
    chk(full === 1'b0, "R1 full after reset", full, 0);
    chk(aempty === 1'b1, "R1 aempty after reset", aempty, 1);
    if (!mode) chk(rd_data === '0, "R1 dout after reset", rd_data, 0);
  endtask

  task automatic run_mode(bit mode);
    mreset(mode);
    cur_tag = "R4";
    for (int i = 0; i < DEPTH + 6; i++) drive(1, 0);
    idle(1);
    @(negedge clk); chk(full === 1'b1, "R4 full after overflow", full, 1);
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) drive(1, 1);
    drive(0, 1); drive(1, 1); drive(1, 0);
    cur_tag = mode ? "R3" : "R2";
    for (int i = 0; i < DEPTH + 6; i++) drive(0, 1);
    idle(1);
    @(negedge clk); chk(empty === 1'b1, "R4 empty after underflow", empty, 1);
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) drive(1, 1);
    for (int i = 0; i < 3; i++) drive(0, 1);
    cur_tag = "R12";
    load_off(5, 3);
    for (int i = 0; i < DEPTH; i++) drive(i < 62, i >= 62);
    cur_tag = "R11";
    drive(1, 1, 1, 1);
    idle(1);
    @(negedge clk); chk(empty === 1'b1, "R11 prst empties", empty, 1);
    for (int i = 0; i < 6; i++) drive(1, 0);
    @(negedge clk); chk(aempty === 1'b0, "R12 offset kept after prst", aempty, 0);
    cur_tag = "R10";
    drive(0, 0, 0, 1);
    for (int i = 0; i < 20; i++) drive(1, 0);
    for (int i = 0; i < 7; i++) drive(0, 1);
    drive(1, 1, 1);
    idle(1);
    for (int i = 0; i < 25; i++) drive(0, 1);
    drive(0, 0, 1);
    for (int i = 0; i < 5; i++) drive(i[0], 1);
    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 2) load_off($urandom_range(0, 70), $urandom_range(0, 70));
      else if (k < 3) drive(1, 1, 0, 1);
      else drive(($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 5));
    end
    idle(2);
  endtask

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run_mode(0);
    run_mode(1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule